// File: doc/BRIEF.md
# Integer Load Formatter

This block sits between the register-read stage of a 32-bit integer pipeline and a word-wide data memory port. It takes one load at a time as an opcode, a base register value and a 16-bit offset. It forms the effective address and presents the containing word address to memory over a valid/ready request channel. When the response arrives, it extracts the addressed byte or halfword and widens it to a 32-bit register result.

The signed variants replicate the top bit of the loaded value into the upper bits, and the unsigned variants fill the upper bits with zeros. Lanes are numbered big-endian by default: address offset 0 names the most significant byte of the word. A halfword or word load at an address that is not naturally aligned never reaches memory. It completes with an alignment fault. An error on the memory response also completes the load with a fault. In both cases the register write is suppressed.

Top module: `load_fmt`

## Requirements
- R1: The effective address is base_i plus offset_i sign-extended to 32 bits. mem_addr_o carries that address with bits 1:0 forced to zero. It is held steady while mem_req_valid_o is high and mem_req_ready_i is low.
- R2: Opcode 0x20 loads a signed byte. Address bits 1:0 pick the lane: 0 selects data bits 31:24, 1 selects 23:16, 2 selects 15:8 and 3 selects 7:0. Bit 7 of the byte is copied into result bits 31:8.
- R3: Opcode 0x24 loads an unsigned byte from the same lane as R2, with result bits 31:8 zero.
- R4: Opcode 0x21 loads a signed halfword. Address bit 1 equal to 0 selects data bits 31:16, and equal to 1 selects 15:0. Bit 15 of the halfword is copied into result bits 31:16.
- R5: Opcode 0x25 loads an unsigned halfword from the same lane as R4, with result bits 31:16 zero.
- R6: Opcode 0x23 returns the whole 32-bit response word unchanged.
- R7: The alignment fault is raised when a halfword load has address bit 0 set, or when a word load has address bits 1:0 not both zero. No memory request is issued. The result appears the cycle after acceptance with res_align_fault_o high, res_wen_o low and res_data_o zero.
- R8: A response with mem_rsp_err_i high completes the load with res_mem_fault_o high, res_wen_o low and res_data_o zero.
- R9: res_valid_o is a single-cycle pulse in the cycle after the response handshake (mem_rsp_valid_i high while a request is outstanding). A successful load has res_wen_o high and both fault outputs low. req_ready_o is high only while no load is in flight.
- R10: Any opcode other than the five loads issues no memory request. It completes the cycle after acceptance with res_wen_o low, both faults low and res_data_o zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Load request present |
| req_ready_o | output | 1 | Block idle and accepting a load |
| opcode_i | input | 6 | Primary opcode of the load |
| base_i | input | 32 | Base register value |
| offset_i | input | 16 | Signed displacement |
| mem_req_valid_o | output | 1 | Memory read request |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_addr_o | output | 32 | Word-aligned read address |
| mem_rsp_valid_i | input | 1 | Memory response present |
| mem_rsp_data_i | input | 32 | Response word |
| mem_rsp_err_i | input | 1 | Response carries an access error |
| res_valid_o | output | 1 | Result pulse |
| res_wen_o | output | 1 | Register write enable |
| res_data_o | output | 32 | Formatted register value |
| res_align_fault_o | output | 1 | Misaligned access fault |
| res_mem_fault_o | output | 1 | Memory access fault |

## Verification
The bench walks every byte and halfword lane with values whose top bit is set and values whose top bit is clear. A swapped lane order or a sign/zero mix-up then returns a visibly wrong upper half. Negative offsets that carry across the word boundary catch an address adder that zero-extends the displacement. Every misaligned pattern for halfword and word loads is driven, including halfword offset 2, which is legal. A design that checked the wrong bits would either request memory for a faulting load or fault a legal one. A stalled request and an error response check that the address holds steady and that the write enable falls on a fault.

// File: rtl/load_fmt_pkg.sv
package load_fmt_pkg;
  typedef enum logic [5:0] {
    OP_LB  = 6'h20,
    OP_LH  = 6'h21,
    OP_LW  = 6'h23,
    OP_LBU = 6'h24,
    OP_LHU = 6'h25
  } ld_op_e;

  typedef enum logic [1:0] {SZ_BYTE, SZ_HALF, SZ_WORD} ld_size_e;

  typedef struct packed {
    logic     valid;
    ld_size_e size;
    logic     sext;
  } ld_dec_t;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT, ST_DONE} ld_state_e;
endpackage

// File: rtl/load_ea_dec.sv
module load_ea_dec
  import load_fmt_pkg::*;
#(
  parameter int AW   = 32,
  parameter int OFFW = 16
) (
  input  logic [5:0]      opcode_i,
  input  logic [AW-1:0]   base_i,
  input  logic [OFFW-1:0] offset_i,
  output logic [AW-1:0]   ea_o,
  output ld_dec_t         dec_o,
  output logic            misalign_o
);
  assign ea_o = base_i + {{(AW-OFFW){offset_i[OFFW-1]}}, offset_i};

  always_comb begin
    dec_o = '{valid: 1'b0, size: SZ_BYTE, sext: 1'b0};
    case (opcode_i)
      OP_LB:  dec_o = '{valid: 1'b1, size: SZ_BYTE, sext: 1'b1};
      OP_LBU: dec_o = '{valid: 1'b1, size: SZ_BYTE, sext: 1'b0};
      OP_LH:  dec_o = '{valid: 1'b1, size: SZ_HALF, sext: 1'b1};
      OP_LHU: dec_o = '{valid: 1'b1, size: SZ_HALF, sext: 1'b0};
      OP_LW:  dec_o = '{valid: 1'b1, size: SZ_WORD, sext: 1'b0};
      default: ;
    endcase
  end

  always_comb begin
    case (dec_o.size)
      SZ_HALF: misalign_o = ea_o[0];
      SZ_WORD: misalign_o = |ea_o[1:0];
      default: misalign_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/load_lane_fmt.sv
module load_lane_fmt
  import load_fmt_pkg::*;
#(
  parameter int DW         = 32,
  parameter bit BIG_ENDIAN = 1'b1,
  localparam int NB        = DW / 8,
  localparam int LW        = $clog2(NB)
) (
  input  logic [DW-1:0] word_i,
  input  logic [LW-1:0] lane_i,
  input  ld_size_e      size_i,
  input  logic          sext_i,
  output logic [DW-1:0] data_o
);
  logic [LW-1:0] byte_idx;
  logic [LW-2:0] half_idx;

  generate
    if (BIG_ENDIAN) begin : g_be
      assign byte_idx = LW'(NB - 1) - lane_i;
      assign half_idx = (LW-1)'(NB/2 - 1) - lane_i[LW-1:1];
    end else begin : g_le
      assign byte_idx = lane_i;
      assign half_idx = lane_i[LW-1:1];
    end
  endgenerate

  logic [DW-1:0] byte_sh, half_sh;
  logic [7:0]    byte_v;
  logic [15:0]   half_v;

  assign byte_sh = word_i >> {byte_idx, 3'b000};
  assign half_sh = word_i >> {half_idx, 4'b0000};
  assign byte_v  = byte_sh[7:0];
  assign half_v  = half_sh[15:0];

  always_comb begin
    case (size_i)
      SZ_BYTE: data_o = {{(DW-8){sext_i & byte_v[7]}}, byte_v};
      SZ_HALF: data_o = {{(DW-16){sext_i & half_v[15]}}, half_v};
      default: data_o = word_i;
    endcase
  end
endmodule

// File: rtl/load_fmt.sv
module load_fmt
  import load_fmt_pkg::*;
#(
  parameter int DW         = 32,
  parameter int OFFW       = 16,
  parameter bit BIG_ENDIAN = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  output logic            req_ready_o,
  input  logic [5:0]      opcode_i,
  input  logic [DW-1:0]   base_i,
  input  logic [OFFW-1:0] offset_i,
  output logic            mem_req_valid_o,
  input  logic            mem_req_ready_i,
  output logic [DW-1:0]   mem_addr_o,
  input  logic            mem_rsp_valid_i,
  input  logic [DW-1:0]   mem_rsp_data_i,
  input  logic            mem_rsp_err_i,
  output logic            res_valid_o,
  output logic            res_wen_o,
  output logic [DW-1:0]   res_data_o,
  output logic            res_align_fault_o,
  output logic            res_mem_fault_o
);
  localparam int LW = $clog2(DW / 8);

  ld_state_e     state_q;
  logic [DW-1:0] ea, ea_q, fmt_data;
  ld_dec_t       dec;
  logic          misalign;
  ld_size_e      size_q;
  logic          sext_q;

  load_ea_dec #(.AW(DW), .OFFW(OFFW)) u_ea_dec (
    .opcode_i  (opcode_i),
    .base_i    (base_i),
    .offset_i  (offset_i),
    .ea_o      (ea),
    .dec_o     (dec),
    .misalign_o(misalign)
  );

  load_lane_fmt #(.DW(DW), .BIG_ENDIAN(BIG_ENDIAN)) u_lane_fmt (
    .word_i(mem_rsp_data_i),
    .lane_i(ea_q[LW-1:0]),
    .size_i(size_q),
    .sext_i(sext_q),
    .data_o(fmt_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q           <= ST_IDLE;
      ea_q              <= '0;
      size_q            <= SZ_BYTE;
      sext_q            <= 1'b0;
      res_wen_o         <= 1'b0;
      res_data_o        <= '0;
      res_align_fault_o <= 1'b0;
      res_mem_fault_o   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_valid_i) begin
          ea_q              <= ea;
          size_q            <= dec.size;
          sext_q            <= dec.sext;
          res_wen_o         <= 1'b0;
          res_data_o        <= '0;
          res_mem_fault_o   <= 1'b0;
          res_align_fault_o <= dec.valid & misalign;
          // unknown opcodes and misaligned loads skip memory
          state_q <= (dec.valid && !misalign) ? ST_REQ : ST_DONE;
        end
        ST_REQ: if (mem_req_ready_i) state_q <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid_i) begin
          res_wen_o       <= !mem_rsp_err_i;
          res_mem_fault_o <= mem_rsp_err_i;
          res_data_o      <= mem_rsp_err_i ? '0 : fmt_data;
          state_q         <= ST_DONE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o     = (state_q == ST_IDLE);
  assign mem_req_valid_o = (state_q == ST_REQ);
  assign mem_addr_o      = {ea_q[DW-1:LW], {LW{1'b0}}};
  assign res_valid_o     = (state_q == ST_DONE);
endmodule

// File: rtl/load_fmt_chk.sv
module load_fmt_chk #(
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_ready_o,
  input logic          mem_req_valid_o,
  input logic          mem_req_ready_i,
  input logic [DW-1:0] mem_addr_o,
  input logic          mem_rsp_valid_i,
  input logic          res_valid_o,
  input logic          res_wen_o,
  input logic          res_align_fault_o,
  input logic          res_mem_fault_o
);
  logic outstanding;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) outstanding <= 1'b0;
    else if (mem_req_valid_o && mem_req_ready_i) outstanding <= 1'b1;
    else if (mem_rsp_valid_i) outstanding <= 1'b0;
  end

  a_r1_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_addr_o));

  a_r1_word_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> mem_addr_o[1:0] == 2'b00);

  a_r7_no_wen_on_align: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && res_align_fault_o |-> !res_wen_o && !res_mem_fault_o);

  a_r8_no_wen_on_memerr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && res_mem_fault_o |-> !res_wen_o);

  a_r9_result_after_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    outstanding && mem_rsp_valid_i |=> res_valid_o);

  a_r9_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o);

  a_r9_busy_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o || outstanding || res_valid_o) |-> !req_ready_o);
endmodule

bind load_fmt load_fmt_chk #(.DW(DW)) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .req_ready_o      (req_ready_o),
  .mem_req_valid_o  (mem_req_valid_o),
  .mem_req_ready_i  (mem_req_ready_i),
  .mem_addr_o       (mem_addr_o),
  .mem_rsp_valid_i  (mem_rsp_valid_i),
  .res_valid_o      (res_valid_o),
  .res_wen_o        (res_wen_o),
  .res_align_fault_o(res_align_fault_o),
  .res_mem_fault_o  (res_mem_fault_o)
);

// File: tb/load_fmt_tb.sv
module load_fmt_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [5:0]  opcode_i = '0;
  logic [31:0] base_i = '0;
  logic [15:0] offset_i = '0;
  logic        mem_req_valid_o;
  logic        mem_req_ready_i = 1'b0;
  logic [31:0] mem_addr_o;
  logic        mem_rsp_valid_i = 1'b0;
  logic [31:0] mem_rsp_data_i = '0;
  logic        mem_rsp_err_i = 1'b0;
  logic        res_valid_o;
  logic        res_wen_o;
  logic [31:0] res_data_o;
  logic        res_align_fault_o;
  logic        res_mem_fault_o;

  int checks = 0;
  int failures = 0;

  always #5 clk_i = ~clk_i;

  load_fmt u_dut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // spec model: big-endian lanes
  function automatic logic [31:0] model(input logic [5:0] op, input logic [1:0] a,
                                        input logic [31:0] w);
    logic [7:0]  b;
    logic [15:0] h;
    b = w[31 - 8*a -: 8];
    h = a[1] ? w[15:0] : w[31:16];
    case (op)
      6'h20: return {{24{b[7]}}, b};
      6'h24: return {24'h0, b};
      6'h21: return {{16{h[15]}}, h};
      6'h25: return {16'h0, h};
      default: return w;
    endcase
  endfunction

  task automatic run_load(input string tag, input logic [5:0] op, input logic [31:0] base,
                          input logic [15:0] off, input logic [31:0] word,
                          input logic err, input int stall);
    logic [31:0] ea;
    logic        known, mis;
    ea    = base + {{16{off[15]}}, off};
    known = op inside {6'h20, 6'h21, 6'h23, 6'h24, 6'h25};
    mis   = (op inside {6'h21, 6'h25} && ea[0]) || (op == 6'h23 && ea[1:0] != 2'b00);
    @(negedge clk_i);
    check({tag, " R9 ready idle"}, 32'(req_ready_o), 32'd1);
    req_valid_i = 1'b1; opcode_i = op; base_i = base; offset_i = off;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    if (!known || mis) begin
      check({tag, " R7/R10 no mem req"}, 32'(mem_req_valid_o), 32'd0);
      check({tag, " R7/R10 res valid"}, 32'(res_valid_o), 32'd1);
      check({tag, " R7 align fault"}, 32'(res_align_fault_o), 32'(known));
      check({tag, " R10 wen low"}, 32'(res_wen_o), 32'd0);
      check({tag, " R10 memfault low"}, 32'(res_mem_fault_o), 32'd0);
      check({tag, " R7 data zero"}, res_data_o, 32'd0);
    end else begin
      check({tag, " R1 req valid"}, 32'(mem_req_valid_o), 32'd1);
      check({tag, " R1 addr"}, mem_addr_o, {ea[31:2], 2'b00});
      check({tag, " R9 busy"}, 32'(req_ready_o), 32'd0);
      for (int i = 0; i < stall; i++) begin
        @(negedge clk_i);
        check({tag, " R1 addr held"}, mem_addr_o, {ea[31:2], 2'b00});
        check({tag, " R1 req held"}, 32'(mem_req_valid_o), 32'd1);
      end
      mem_req_ready_i = 1'b1;
      @(negedge clk_i);
      mem_req_ready_i = 1'b0;
      check({tag, " R9 req dropped"}, 32'(mem_req_valid_o), 32'd0);
      @(negedge clk_i);
      check({tag, " R9 no early result"}, 32'(res_valid_o), 32'd0);
      mem_rsp_valid_i = 1'b1; mem_rsp_data_i = word; mem_rsp_err_i = err;
      @(negedge clk_i);
      mem_rsp_valid_i = 1'b0; mem_rsp_err_i = 1'b0; mem_rsp_data_i = 32'hDEAD_BEEF;
      check({tag, " R9 res valid"}, 32'(res_valid_o), 32'd1);
      check({tag, " R8/R9 wen"}, 32'(res_wen_o), 32'(!err));
      check({tag, " R8 mem fault"}, 32'(res_mem_fault_o), 32'(err));
      check({tag, " R9 no align fault"}, 32'(res_align_fault_o), 32'd0);
      check({tag, " R2-6 data"}, res_data_o, err ? 32'd0 : model(op, ea[1:0], word));
    end
    @(negedge clk_i);
    check({tag, " R9 pulse ends"}, 32'(res_valid_o), 32'd0);
  endtask

  task automatic t_reset();
    check("R9 reset ready", 32'(req_ready_o), 32'd1);
    check("R9 reset res_valid", 32'(res_valid_o), 32'd0);
    check("R1 reset mem_req", 32'(mem_req_valid_o), 32'd0);
  endtask

  task automatic t_bytes();
    for (int a = 0; a < 4; a++) begin
      run_load("R2 lb neg", 6'h20, 32'h1000, 16'(a), 32'h80_91_A2_F3, 1'b0, 0);
      run_load("R2 lb pos", 6'h20, 32'h1000, 16'(a), 32'h12_34_56_78, 1'b0, 0);
      run_load("R3 lbu", 6'h24, 32'h2000, 16'(a), 32'h80_91_A2_F3, 1'b0, 0);
    end
    run_load("R1 R2 negoff", 6'h20, 32'h0000_1003, 16'hFFFE, 32'h11_22_83_44, 1'b0, 0);
  endtask

  task automatic t_halves();
    run_load("R4 lh hi", 6'h21, 32'h3000, 16'h0, 32'h8123_7F00, 1'b0, 0);
    run_load("R4 lh lo", 6'h21, 32'h3000, 16'h2, 32'h7F00_9ABC, 1'b0, 0);
    run_load("R4 lh pos", 6'h21, 32'h3000, 16'h2, 32'hFFFF_1234, 1'b0, 0);
    run_load("R5 lhu hi", 6'h25, 32'h3000, 16'h0, 32'h8123_7F00, 1'b0, 0);
    run_load("R5 lhu lo", 6'h25, 32'h3002, 16'h0, 32'h0000_F00D, 1'b0, 0);
  endtask

  task automatic t_word();
    run_load("R6 lw", 6'h23, 32'h4000, 16'h8, 32'hCAFE_F00D, 1'b0, 0);
    run_load("R1 R6 lw stall neg", 6'h23, 32'h0001_0000, 16'hFFFC, 32'h8000_0001, 1'b0, 3);
  endtask

  task automatic t_misalign();
    run_load("R7 lh odd", 6'h21, 32'h5000, 16'h1, 32'h0, 1'b0, 0);
    run_load("R7 lhu odd", 6'h25, 32'h5003, 16'h0, 32'h0, 1'b0, 0);
    run_load("R7 lw +1", 6'h23, 32'h5000, 16'h1, 32'h0, 1'b0, 0);
    run_load("R7 lw +2", 6'h23, 32'h5000, 16'h2, 32'h0, 1'b0, 0);
    run_load("R7 lw +3", 6'h23, 32'h5002, 16'h1, 32'h0, 1'b0, 0);
  endtask

  task automatic t_memerr();
    run_load("R8 lw err", 6'h23, 32'h6000, 16'h0, 32'hFFFF_FFFF, 1'b1, 1);
    run_load("R8 lb err", 6'h20, 32'h6001, 16'h0, 32'hFFFF_FFFF, 1'b1, 0);
    run_load("R8 recover", 6'h24, 32'h6001, 16'h0, 32'h00AB_0000, 1'b0, 0);
  endtask

  task automatic t_unknown();
    run_load("R10 op22", 6'h22, 32'h7000, 16'h0, 32'h0, 1'b0, 0);
    run_load("R10 op0f", 6'h0F, 32'h7001, 16'h0, 32'h0, 1'b0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_bytes();
    t_halves();
    t_word();
    t_misalign();
    t_memerr();
    t_unknown();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule